// File: doc/BRIEF.md
# Divided Clock Health Monitor

This block judges whether a clock that should run at one eighth of a fast reference clock is still healthy. The whole block runs on the fast clock. It brings the divided clock into the fast domain through a two-stage synchronizer and takes one sample per fast cycle. Over a window of 8, 16, 24 or 32 samples it counts how often the divided clock was high. A healthy divided clock gives a high-count of half the window. When the count strays from that value by more than a programmable tolerance, or when the samples never change inside a window, the block emits a single-cycle request to reset the clock synthesizer.

A programmable holdoff after each request gives the synthesizer time to relock before another request can be issued. The synthesizer's two status indications are also captured into sticky fault flags: one says the input clock was lost, the other says the synthesized outputs stopped. Together with the duty-count and stuck-level faults, these flags hold until software pulses a clear input.

Top module: `dclk_health_mon`

## Requirements
- R1: The window length is 8*(win_sel+1) samples (win_sel 0..3 gives 8, 16, 24, 32). win_sel is captured during reset and again at each window boundary, so a change takes effect from the next window.
- R2: A window whose high-count differs from 4*(win_sel+1) by more than tol is a duty fault. It produces a rst_req pulse (subject to R5) and sets flt_duty.
- R3: A window whose high-count is within tol of the expected value, the boundary value included, produces neither a request nor a flag.
- R4: rst_req is high for exactly one cycle. For the first window after reset is released, the pulse follows rising edge N+1, where N is the window length and edge 1 is the first edge with rst_n high.
- R5: After a rst_req pulse, no further pulse occurs during the next `holdoff` fast cycles. Faulty windows in that time still set the flags. With holdoff 0, every faulty window requests.
- R6: A window in which no two consecutive samples differ sets flt_stuck and counts as a fault for rst_req.
- R7: A one-cycle high on in_lost sets flt_in_lost, and a one-cycle high on out_stopped sets flt_out_stop. Each flag is set within three cycles, and the other flag is unaffected.
- R8: All four flags stay set until flag_clr is sampled high. If a flag's set event and flag_clr arrive in the same cycle, the flag ends up set.
- R9: flag_clr does not move the window boundary or discard the samples of the window in progress.
- R10: While rst_n is low at a clock edge, rst_req and all flags are cleared, along with the window position, the counters and the holdoff timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; every register uses it |
| rst_n | input | 1 | Synchronous active-low reset |
| div_clk | input | 1 | Divided clock under observation, asynchronous |
| win_sel | input | SEL_W (2) | Window length code: 8*(win_sel+1) samples |
| tol | input | TOL_W (6) | Allowed deviation of the high-count, in samples |
| holdoff | input | HOLD_W (8) | Fast cycles during which requests are suppressed after a pulse |
| in_lost | input | 1 | Status: input clock of the synthesizer is missing |
| out_stopped | input | 1 | Status: synthesized outputs have stopped |
| flag_clr | input | 1 | Clears all sticky flags |
| rst_req | output | 1 | Single-cycle reset request to the synthesizer |
| flt_duty | output | 1 | Sticky: high-count out of tolerance |
| flt_stuck | output | 1 | Sticky: no transition in a window |
| flt_in_lost | output | 1 | Sticky: in_lost was seen |
| flt_out_stop | output | 1 | Sticky: out_stopped was seen |

## Verification
The bench builds the block with its default parameters: SEL_W=2, so all four window lengths up to 32 samples are reachable, TOL_W=6 and HOLD_W=8. Because the divided clock is generated with an exact high time per eight fast cycles, every window's high-count is known in advance. This makes the tolerance boundary testable from both sides: a deviation equal to tol must pass and one above it must fail, in 24- and 32-sample windows. An 8-bit holdoff of 20 spans more than two 8-sample windows, so a suppressed request and the next allowed one both fall inside a short run. Pulse cycles are timed relative to reset release, which exposes a window boundary shifted by a clear or by a win_sel change.

// File: rtl/dhm_pkg.sv
// Shared constants, flag indices and the window-length helper for the
// divided clock health monitor.
package dhm_pkg;

    // Nominal ratio between the fast clock and the monitored clock.
    localparam int BASE_DIV = 8;

    // Number of sticky fault flags.
    localparam int NUM_FLAGS = 4;

    // Position of each fault in the sticky flag vector.
    typedef enum logic [1:0] {
        FLG_DUTY    = 2'd0,
        FLG_STUCK   = 2'd1,
        FLG_INLOST  = 2'd2,
        FLG_OUTSTOP = 2'd3
    } flag_e;

    // Number of samples in a window for a given select code.
    function automatic int win_len(input int sel);
        return BASE_DIV * (sel + 1);
    endfunction

    // Expected high-count (half the window) for a given select code.
    function automatic int win_half(input int sel);
        return (BASE_DIV / 2) * (sel + 1);
    endfunction

endpackage

// File: rtl/dhm_sync.sv
// Two-stage synchronizer, one lane per bit.
// Assumes: inputs may be asynchronous to clk; pulses meant to pass must last
// at least one clk period. The flops have no reset on purpose, so the
// synchronized value stays valid through a reset of the rest of the block.
module dhm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;
    logic [W-1:0] stable;

    // Shift each lane through two flops.
    always_ff @(posedge clk) begin
        meta   <= d;
        stable <= meta;
    end

    assign q = stable;

endmodule

// File: rtl/dhm_window.sv
// Window sampler: counts high samples of the synchronized divided clock over
// a window of win_len(sel) cycles, and notes whether any two consecutive
// samples in the window differed. Presents one registered verdict per window.
// Assumes: smp is already synchronous to clk; win_sel is taken at reset and at
// each window boundary only.
module dhm_window #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic [SEL_W-1:0] win_sel,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             stuck_o,
    output logic [SEL_W-1:0] sel_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] len;
    logic             prev;
    logic             seen_chg;
    logic             chg;
    logic             last;
    logic [CNT_W-1:0] smp_ext;
    logic [CNT_W-1:0] sel_len;

    // Length of the window in progress and of the one being reported.
    always_comb begin
        len     = CNT_W'(dhm_pkg::win_len(int'(sel_q)));
        sel_len = CNT_W'(dhm_pkg::win_len(int'(sel_o)));
        smp_ext = {{(CNT_W-1){1'b0}}, smp};
        last    = (pos == len - ONE);
        chg     = (pos != '0) && (smp != prev);
    end

    // Advance the window, accumulate high samples and close each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= win_sel;
            pos      <= '0;
            acc      <= '0;
            prev     <= 1'b0;
            seen_chg <= 1'b0;
            done_o   <= 1'b0;
            cnt_o    <= '0;
            stuck_o  <= 1'b0;
            sel_o    <= '0;
        end else begin
            prev   <= smp;
            done_o <= 1'b0;
            if (last) begin
                done_o   <= 1'b1;
                cnt_o    <= acc + smp_ext;
                stuck_o  <= !(seen_chg || chg);
                sel_o    <= sel_q;
                sel_q    <= win_sel;
                pos      <= '0;
                acc      <= '0;
                seen_chg <= 1'b0;
            end else begin
                pos <= pos + ONE;
                acc <= acc + smp_ext;
                if (chg) begin
                    seen_chg <= 1'b1;
                end
            end
        end
    end

    // R1
    pos_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos < len);

    // R6
    stuck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && stuck_o) |-> (cnt_o == '0 || cnt_o == sel_len));

endmodule

// File: rtl/dhm_judge.sv
// Judge: compares each window's high-count with half the window, applies the
// tolerance, and issues a one-cycle reset request unless the holdoff timer is
// still running. Emits one-cycle fault events for the sticky flags.
// Assumes: done_i is a single-cycle strobe at most once every 8 cycles.
module dhm_judge #(
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 6,
    parameter int TOL_W  = 6,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              stuck_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [TOL_W-1:0]  tol,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              rst_req,
    output logic              duty_ev,
    output logic              stuck_ev
);

    localparam logic [HOLD_W-1:0] HONE = {{(HOLD_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  expect_cnt;
    logic [CNT_W-1:0]  dev;
    logic              duty_bad;
    logic              any_bad;
    logic [HOLD_W-1:0] hold_cnt;

    // Absolute deviation of the count from the half-window value.
    always_comb begin
        expect_cnt = CNT_W'(dhm_pkg::win_half(int'(sel_i)));
        dev        = (cnt_i >= expect_cnt) ? (cnt_i - expect_cnt)
                                           : (expect_cnt - cnt_i);
        duty_bad   = done_i && (int'(dev) > int'(tol));
        any_bad    = duty_bad || (done_i && stuck_i);
    end

    // Issue requests, run the holdoff timer and register fault events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            hold_cnt <= '0;
            duty_ev  <= 1'b0;
            stuck_ev <= 1'b0;
        end else begin
            rst_req  <= 1'b0;
            duty_ev  <= duty_bad;
            stuck_ev <= done_i && stuck_i;
            if (any_bad && hold_cnt == '0) begin
                rst_req  <= 1'b1;
                hold_cnt <= holdoff;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - HONE;
            end
        end
    end

    // R4
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |=> !rst_req);

    // R5
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (hold_cnt == $past(holdoff)));

endmodule

// File: rtl/dhm_flags.sv
// Sticky fault flags: each bit is set by its event and cleared by the clear
// input. A set event in the same cycle as the clear leaves the bit set.
// Assumes: events and clear are synchronous to clk.
module dhm_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags
);

    // Hold, clear or set the flag bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (clr_i ? '0 : flags) | set_i;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags[i]);

        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_i) |=> flags[i]);
    end

endmodule

// File: rtl/dclk_health_mon.sv
// Divided clock health monitor (top). Synchronizes the divided clock and the
// two synthesizer status inputs, judges the divided clock per window, and
// exposes a reset request plus four sticky fault flags.
// Assumes: clk is the fast clock, nominally 8x the monitored clock; status
// inputs are levels or pulses of at least one clk period.
module dclk_health_mon #(
    parameter int SEL_W  = 2,
    parameter int TOL_W  = 6,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_clk,
    input  logic [SEL_W-1:0]  win_sel,
    input  logic [TOL_W-1:0]  tol,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic              in_lost,
    input  logic              out_stopped,
    input  logic              flag_clr,
    output logic              rst_req,
    output logic              flt_duty,
    output logic              flt_stuck,
    output logic              flt_in_lost,
    output logic              flt_out_stop
);

    import dhm_pkg::*;

    localparam int MAX_WIN = BASE_DIV * (2 ** SEL_W);
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    logic [2:0]           sync_q;
    logic                 smp;
    logic                 lost_s;
    logic                 stop_s;
    logic                 done;
    logic [CNT_W-1:0]     cnt;
    logic                 stuck;
    logic [SEL_W-1:0]     sel_rep;
    logic                 duty_ev;
    logic                 stuck_ev;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;

    dhm_sync #(.W(3)) u_sync (
        .clk (clk),
        .d   ({out_stopped, in_lost, div_clk}),
        .q   (sync_q)
    );

    assign smp    = sync_q[0];
    assign lost_s = sync_q[1];
    assign stop_s = sync_q[2];

    dhm_window #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp),
        .win_sel (win_sel),
        .done_o  (done),
        .cnt_o   (cnt),
        .stuck_o (stuck),
        .sel_o   (sel_rep)
    );

    dhm_judge #(.SEL_W(SEL_W), .CNT_W(CNT_W), .TOL_W(TOL_W), .HOLD_W(HOLD_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .cnt_i    (cnt),
        .stuck_i  (stuck),
        .sel_i    (sel_rep),
        .tol      (tol),
        .holdoff  (holdoff),
        .rst_req  (rst_req),
        .duty_ev  (duty_ev),
        .stuck_ev (stuck_ev)
    );

    // Gather the fault events into the flag vector.
    always_comb begin
        set_vec              = '0;
        set_vec[FLG_DUTY]    = duty_ev;
        set_vec[FLG_STUCK]   = stuck_ev;
        set_vec[FLG_INLOST]  = lost_s;
        set_vec[FLG_OUTSTOP] = stop_s;
    end

    dhm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (flag_clr),
        .flags (flags)
    );

    assign flt_duty     = flags[FLG_DUTY];
    assign flt_stuck    = flags[FLG_STUCK];
    assign flt_in_lost  = flags[FLG_INLOST];
    assign flt_out_stop = flags[FLG_OUTSTOP];

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_req && flags == '0));

    // R2
    duty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_ev |=> flt_duty);

endmodule

// File: tb/dclk_health_mon_test.sv
module dclk_health_mon_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_clk = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [5:0] tol = 6'd1;
    logic [7:0] holdoff = 8'd0;
    logic       in_lost = 1'b0;
    logic       out_stopped = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rst_req;
    logic       flt_duty, flt_stuck, flt_in_lost, flt_out_stop;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int hi_len = 4;
    int ph = 0;
    int npulse = 0;
    int p1 = 0;
    int p2 = 0;

    dclk_health_mon uut (
        .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .win_sel(win_sel),
        .tol(tol), .holdoff(holdoff), .in_lost(in_lost),
        .out_stopped(out_stopped), .flag_clr(flag_clr), .rst_req(rst_req),
        .flt_duty(flt_duty), .flt_stuck(flt_stuck),
        .flt_in_lost(flt_in_lost), .flt_out_stop(flt_out_stop)
    );

    always #5 clk = ~clk;

    // divided clock: hi_len high cycles out of every 8
    always @(negedge clk) begin
        ph = (ph + 1) % 8;
        div_clk = (ph < hi_len);
    end

    // edges since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // pulse log
    always @(negedge clk) begin
        if (!rst_n) begin
            npulse = 0; p1 = 0; p2 = 0;
        end else if (rst_req) begin
            npulse = npulse + 1;
            if (npulse == 1) p1 = cyc;
            else if (npulse == 2) p2 = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input int sel, input int hi, input int t, input int h);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        win_sel = 2'(sel); hi_len = hi; tol = 6'(t); holdoff = 8'(h);
        flag_clr = 1'b0; in_lost = 1'b0; out_stopped = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic wait_to(input int n);
        do @(negedge clk); while (cyc < n);
        #2;
    endtask

    task automatic t_reset();
        start(0, 4, 1, 0);
        rst_n = 1'b0;
        @(negedge clk); #2;
        chk("R10 rst_req in reset", int'(rst_req), 0);
        chk("R10 flags in reset", int'({flt_duty, flt_stuck, flt_in_lost, flt_out_stop}), 0);
    endtask

    task automatic t_good();
        start(0, 4, 1, 0);
        wait_to(100);
        chk("R3 no pulse w8", npulse, 0);
        chk("R3 duty flag w8", int'(flt_duty), 0);
        chk("R6 stuck flag good clock", int'(flt_stuck), 0);
        start(3, 4, 0, 0);
        wait_to(140);
        chk("R3 no pulse w32 tol0", npulse, 0);
    endtask

    task automatic t_duty();
        start(0, 6, 1, 0);
        wait_to(41);
        chk("R4 first pulse cycle", p1, 9);
        chk("R5 pulses with holdoff 0", npulse, 5);
        chk("R2 duty flag", int'(flt_duty), 1);
        chk("R6 no stuck flag", int'(flt_stuck), 0);
    endtask

    task automatic t_tol();
        start(3, 5, 4, 0);
        wait_to(140);
        chk("R3 w32 dev4 tol4", npulse, 0);
        start(3, 5, 3, 0);
        wait_to(40);
        chk("R2 w32 dev4 tol3", p1, 33);
        start(2, 3, 2, 0);
        wait_to(30);
        chk("R2 w24 dev3 tol2", p1, 25);
        start(2, 3, 3, 0);
        wait_to(120);
        chk("R3 w24 dev3 tol3", npulse, 0);
        start(0, 3, 0, 0);
        wait_to(12);
        chk("R2 w8 dev1 tol0", p1, 9);
    endtask

    task automatic t_hold();
        start(0, 6, 1, 20);
        wait_to(50);
        chk("R5 first pulse", p1, 9);
        chk("R5 second pulse after holdoff", p2, 33);
        chk("R5 flag set during holdoff", int'(flt_duty), 1);
    endtask

    task automatic t_stuck();
        start(0, 0, 1, 0);
        wait_to(20);
        chk("R6 stuck low pulse", p1, 9);
        chk("R6 stuck low flag", int'(flt_stuck), 1);
        start(0, 8, 1, 0);
        wait_to(20);
        chk("R6 stuck high flag", int'(flt_stuck), 1);
    endtask

    task automatic t_winsel();
        start(0, 6, 1, 0);
        wait_to(3);
        win_sel = 2'd3;
        wait_to(45);
        chk("R1 first window of 8", p1, 9);
        chk("R1 next window of 32", p2, 41);
    endtask

    task automatic t_clear();
        start(0, 6, 1, 0);
        wait_to(12);
        chk("R8 flag before clear", int'(flt_duty), 1);
        flag_clr = 1'b1;
        @(negedge clk); #1;
        flag_clr = 1'b0;
        wait_to(14);
        chk("R8 flag cleared", int'(flt_duty), 0);
        wait_to(17);
        flag_clr = 1'b1;
        wait_to(18);
        flag_clr = 1'b0;
        chk("R8 set wins over clear", int'(flt_duty), 1);
        chk("R9 window kept after clear", p2, 17);
    endtask

    task automatic t_status();
        start(0, 4, 1, 0);
        wait_to(5);
        in_lost = 1'b1;
        wait_to(6);
        in_lost = 1'b0;
        wait_to(10);
        chk("R7 in_lost captured", int'(flt_in_lost), 1);
        chk("R7 out_stop untouched", int'(flt_out_stop), 0);
        wait_to(30);
        chk("R8 in_lost sticky", int'(flt_in_lost), 1);
        out_stopped = 1'b1;
        wait_to(31);
        out_stopped = 1'b0;
        wait_to(35);
        chk("R7 out_stopped captured", int'(flt_out_stop), 1);
        rst_n = 1'b0;
        @(negedge clk); #2;
        chk("R10 reset clears flags", int'({flt_in_lost, flt_out_stop}), 0);
        start(0, 4, 1, 0);
        in_lost = 1'b1;
        wait_to(2);
        in_lost = 1'b0;
        wait_to(8);
        flag_clr = 1'b1;
        wait_to(9);
        flag_clr = 1'b0;
        wait_to(11);
        chk("R8 clear status flag", int'(flt_in_lost), 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_good();
        t_duty();
        t_tol();
        t_hold();
        t_stuck();
        t_winsel();
        t_clear();
        t_status();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule